// File: doc/BRIEF.md
# Dual-Pointer Sequential Frame Buffer

This block is a byte-wide storage array with two sides that share nothing except the array. A producer pushes bytes in on its own clock. A consumer pulls bytes out on a second, unrelated clock. Each side keeps its own address counter. The counter steps by one location for every accepted byte and returns to the first location after the last one.

There are no occupancy flags. The two sides stay in step by restarting their counters at frame boundaries. A video front end clears the write counter at the start of each image and then streams pixels, with an active-low strobe gating out blanking data. A bus controller clears the read counter and drains the image. A read needs two active-low qualifiers together: a fetch request and a bus drive enable. When the drive enable is high, the data bus reads as zero.

A write is accepted at one write-clock edge and reaches the array at the next edge. The array holds `DEPTH` locations of `DATA_W` bits. The full-size frame store uses 262144 × 8; the default is 1024 × 8 so that elaboration stays light.

Top module: `frame_seq_buffer`

## Requirements
- R1: Bytes written after a write-counter clear land in locations 0, 1, 2, … in order, and reads after a read-counter clear return them in the same order, for a store of `DEPTH` entries of `DATA_W` bits.
- R2: With `wr_rst` high at a write-clock edge, the write counter becomes 0, and the next accepted byte goes to location 0.
- R3: At a write-clock edge with `wr_en_n` low and `wr_rst` low, the byte is captured and the write counter steps by one. The byte is stored into the array at the following write-clock edge. With `wr_en_n` high, nothing is stored and the counter holds.
- R4: With `rd_rst` high at a read-clock edge, the read counter becomes 0 and the output register becomes 0. The next qualified read returns location 0.
- R5: At a read-clock edge with `rd_en_n` low, `out_en_n` low and `rd_rst` low, the byte at the read counter appears on `rd_data` after that edge, and the counter steps by one.
- R6: While `out_en_n` is high, `rd_data` is zero and the read counter holds. While `rd_en_n` is high and `out_en_n` is low, `rd_data` keeps the last fetched byte and the counter holds.
- R7: Each counter moves from location `DEPTH-1` to location 0. A write past the end overwrites location 0 onward.
- R8: A counter clear overrides that side's enables in the same cycle. No byte is captured or fetched, and no counter steps.
- R9: Writes and reads run at the same time on unrelated clocks without disturbing each other, as long as they touch different locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous write-counter clear, active high |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | DATA_W | Byte to store |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Synchronous read-counter clear, active high |
| rd_en_n | input | 1 | Fetch request, active low |
| out_en_n | input | 1 | Bus drive enable, active low |
| rd_data | output | DATA_W | Fetched byte, or zero while the bus is released |

## Verification
The bench builds the block with `DEPTH` = 16 and `DATA_W` = 8. With that depth, a frame of eighteen bytes runs both counters past the last location, so the wrap and the overwrite of locations 0 and 1 are reached in a short run. The two clocks have the same period but a one-nanosecond phase offset. In the last phase, writes into a low region overlap in time with reads from a higher region, which exercises R9.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

   // Action taken by the producer side at a write-clock edge
   typedef enum logic [1:0] {
      WR_HOLD    = 2'd0,
      WR_CAPTURE = 2'd1,
      WR_CLEAR   = 2'd2
   } wr_act_e;

   // Action taken by the consumer side at a read-clock edge
   typedef enum logic [1:0] {
      RD_HOLD  = 2'd0,
      RD_FETCH = 2'd1,
      RD_CLEAR = 2'd2
   } rd_act_e;

   // Clear wins over the strobe on the same edge
   function automatic wr_act_e wr_decode(input logic clr, input logic en_n);
      if (clr)        return WR_CLEAR;
      else if (!en_n) return WR_CAPTURE;
      else            return WR_HOLD;
   endfunction

   function automatic rd_act_e rd_decode(input logic clr, input logic en_n,
                                         input logic oe_n);
      if (clr)                return RD_CLEAR;
      else if (!en_n && !oe_n) return RD_FETCH;
      else                    return RD_HOLD;
   endfunction

endpackage

// File: rtl/fsb_wr_port.sv
module fsb_wr_port
   import fsb_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 8,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              ptr_rst,
   input  logic              en_n,
   input  logic [DATA_W-1:0] din,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DATA_W-1:0] mem_din,
   output logic [AW-1:0]     ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   wr_act_e          act;
   logic [AW-1:0]    ptr_q;
   logic             stg_vld_q;
   logic [AW-1:0]    stg_addr_q;
   logic [DATA_W-1:0] stg_data_q;

   assign act = wr_decode(ptr_rst, en_n);

   // Counter
   always_ff @(posedge clk) begin
      unique case (act)
         WR_CLEAR:   ptr_q <= '0;
         WR_CAPTURE: ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         default:    ptr_q <= ptr_q;
      endcase
   end

   // One-cycle staging register in front of the array
   always_ff @(posedge clk) begin
      stg_vld_q <= (act == WR_CAPTURE);
      if (act == WR_CAPTURE) begin
         stg_addr_q <= ptr_q;
         stg_data_q <= din;
      end
   end

   assign mem_we   = stg_vld_q;
   assign mem_addr = stg_addr_q;
   assign mem_din  = stg_data_q;
   assign ptr      = ptr_q;

endmodule

// File: rtl/fsb_rd_port.sv
module fsb_rd_port
   import fsb_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 8,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              ptr_rst,
   input  logic              en_n,
   input  logic              oe_n,
   output logic [AW-1:0]     mem_addr,
   input  logic [DATA_W-1:0] mem_dout,
   output logic [DATA_W-1:0] dout,
   output logic [AW-1:0]     ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   rd_act_e           act;
   logic [AW-1:0]     ptr_q;
   logic [DATA_W-1:0] out_q;

   assign act = rd_decode(ptr_rst, en_n, oe_n);

   always_ff @(posedge clk) begin
      unique case (act)
         RD_CLEAR: begin
            ptr_q <= '0;
            out_q <= '0;
         end
         RD_FETCH: begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            out_q <= mem_dout;
         end
         default: begin
            ptr_q <= ptr_q;
            out_q <= out_q;
         end
      endcase
   end

   assign mem_addr = ptr_q;
   // Released bus reads as zero
   assign dout     = oe_n ? '0 : out_q;
   assign ptr      = ptr_q;

endmodule

// File: rtl/fsb_mem.sv
module fsb_mem #(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 8,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   // Asynchronous read port; the consumer side registers the result
   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign rdata = store[raddr];
      end else begin : g_npow2
         assign rdata = (int'(raddr) < DEPTH) ? store[raddr] : '0;
      end
   endgenerate

endmodule

// File: rtl/frame_seq_buffer.sv
module frame_seq_buffer #(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 8
) (
   input  logic              wr_clk,
   input  logic              wr_rst,
   input  logic              wr_en_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_rst,
   input  logic              rd_en_n,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] rd_data
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("frame_seq_buffer: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("frame_seq_buffer: DATA_W must be at least 1");
      end
   endgenerate

   logic              mem_we_w;
   logic [AW-1:0]     mem_waddr_w;
   logic [DATA_W-1:0] mem_wdata_w;
   logic [AW-1:0]     mem_raddr_w;
   logic [DATA_W-1:0] mem_rdata_w;
   logic [AW-1:0]     wr_ptr_w;
   logic [AW-1:0]     rd_ptr_w;

   fsb_wr_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_wr (
      .clk      (wr_clk),
      .ptr_rst  (wr_rst),
      .en_n     (wr_en_n),
      .din      (wr_data),
      .mem_we   (mem_we_w),
      .mem_addr (mem_waddr_w),
      .mem_din  (mem_wdata_w),
      .ptr      (wr_ptr_w)
   );

   fsb_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
      .wclk  (wr_clk),
      .we    (mem_we_w),
      .waddr (mem_waddr_w),
      .wdata (mem_wdata_w),
      .raddr (mem_raddr_w),
      .rdata (mem_rdata_w)
   );

   fsb_rd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_rd (
      .clk      (rd_clk),
      .ptr_rst  (rd_rst),
      .en_n     (rd_en_n),
      .oe_n     (out_en_n),
      .mem_addr (mem_raddr_w),
      .mem_dout (mem_rdata_w),
      .dout     (rd_data),
      .ptr      (rd_ptr_w)
   );

endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
   parameter int DEPTH = 1024,
   parameter int AW    = $clog2(DEPTH)
) (
   input logic          wr_clk,
   input logic          wr_rst,
   input logic          wr_en_n,
   input logic          mem_we,
   input logic [AW-1:0] wr_ptr,
   input logic          rd_clk,
   input logic          rd_rst,
   input logic          rd_en_n,
   input logic          out_en_n,
   input logic [AW-1:0] rd_ptr
);

   function automatic logic [AW-1:0] succ(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   AST_WPTR_CLEAR: assert property (@(posedge wr_clk)
      wr_rst |=> (wr_ptr == '0));                                        // R2

   AST_WPTR_ADVANCE: assert property (@(posedge wr_clk) disable iff (wr_rst)
      !wr_en_n |=> (wr_ptr == succ($past(wr_ptr))));                     // R7

   AST_WPTR_IDLE: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_en_n |=> $stable(wr_ptr));                                      // R3

   AST_STORE_FOLLOWS: assert property (@(posedge wr_clk) disable iff (wr_rst)
      !wr_en_n |=> mem_we);                                              // R3

   AST_STORE_CAUSE: assert property (@(posedge wr_clk) disable iff (wr_rst)
      mem_we |-> $past(!wr_en_n));                                       // R3

   AST_CLEAR_NO_STORE: assert property (@(posedge wr_clk)
      wr_rst |=> !mem_we);                                               // R8

   AST_RPTR_CLEAR: assert property (@(posedge rd_clk)
      rd_rst |=> (rd_ptr == '0));                                        // R4

   AST_RPTR_ADVANCE: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (!rd_en_n && !out_en_n) |=> (rd_ptr == succ($past(rd_ptr))));     // R5

   AST_RPTR_IDLE: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rd_en_n || out_en_n) |=> $stable(rd_ptr));                        // R6

endmodule

bind frame_seq_buffer fsb_checker #(.DEPTH(DEPTH), .AW(AW)) u_fsb_chk (
   .wr_clk   (wr_clk),
   .wr_rst   (wr_rst),
   .wr_en_n  (wr_en_n),
   .mem_we   (mem_we_w),
   .wr_ptr   (wr_ptr_w),
   .rd_clk   (rd_clk),
   .rd_rst   (rd_rst),
   .rd_en_n  (rd_en_n),
   .out_en_n (out_en_n),
   .rd_ptr   (rd_ptr_w)
);

// File: tb/test_frame_seq_buffer.sv
module test_frame_seq_buffer;

   localparam int DEPTH  = 16;
   localparam int DATA_W = 8;

   logic              wr_clk = 1'b0;
   logic              rd_clk = 1'b0;
   logic              wr_rst = 1'b1;
   logic              wr_en_n = 1'b1;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_rst = 1'b1;
   logic              rd_en_n = 1'b1;
   logic              out_en_n = 1'b0;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference model
   logic [DATA_W-1:0] ref_mem [DEPTH];
   int ref_wptr = 0;
   int ref_rptr = 0;
   logic [DATA_W-1:0] exp_q [$];
   logic fire = 1'b0;

   always #2 wr_clk = ~wr_clk;
   initial begin
      #1;
      forever #2 rd_clk = ~rd_clk;
   end

   frame_seq_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_frame_seq_buffer (
      .wr_clk   (wr_clk),
      .wr_rst   (wr_rst),
      .wr_en_n  (wr_en_n),
      .wr_data  (wr_data),
      .rd_clk   (rd_clk),
      .rd_rst   (rd_rst),
      .rd_en_n  (rd_en_n),
      .out_en_n (out_en_n),
      .rd_data  (rd_data)
   );

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Monitor: compares each qualified read with the scoreboard head
   always @(posedge rd_clk) fire <= !rd_en_n && !out_en_n && !rd_rst;
   always @(posedge rd_clk) begin
      #1;
      if (fire) begin
         if (exp_q.size() == 0) check("R5 unexpected read", rd_data, 8'hxx);
         else check("R5 read data", rd_data, exp_q.pop_front());
      end
   end

   // Write-side driver
   task automatic wr_byte(input logic [DATA_W-1:0] d);
      @(negedge wr_clk);
      wr_rst = 1'b0; wr_en_n = 1'b0; wr_data = d;
      ref_mem[ref_wptr] = d;
      ref_wptr = (ref_wptr + 1) % DEPTH;
   endtask

   task automatic wr_idle(input int n, input logic [DATA_W-1:0] junk);
      for (int i = 0; i < n; i++) begin
         @(negedge wr_clk);
         wr_rst = 1'b0; wr_en_n = 1'b1; wr_data = junk ^ DATA_W'(i);
      end
   endtask

   task automatic wr_clear(input logic en_n);
      @(negedge wr_clk);
      wr_rst = 1'b1; wr_en_n = en_n; wr_data = 8'hFF;
      ref_wptr = 0;
   endtask

   // Read-side driver
   task automatic rd_byte();
      @(negedge rd_clk);
      rd_rst = 1'b0; rd_en_n = 1'b0; out_en_n = 1'b0;
      exp_q.push_back(ref_mem[ref_rptr]);
      ref_rptr = (ref_rptr + 1) % DEPTH;
   endtask

   task automatic rd_set(input logic en_n, input logic oe_n);
      @(negedge rd_clk);
      rd_rst = 1'b0; rd_en_n = en_n; out_en_n = oe_n;
   endtask

   task automatic rd_clear(input logic en_n);
      @(negedge rd_clk);
      rd_rst = 1'b1; rd_en_n = en_n; out_en_n = 1'b0;
      ref_rptr = 0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // Reset state (R4): output register cleared, bus driven
      repeat (3) @(negedge wr_clk);
      wr_idle(1, 8'h00);
      rd_set(1'b1, 1'b0);
      @(posedge rd_clk); #1;
      check("R4 reset output", rd_data, '0);

      // R1/R3: sequential frame with gaps in the strobe
      for (int i = 0; i < 6; i++) begin
         wr_byte(8'hA0 + DATA_W'(i));
         wr_idle(1, 8'h5C);               // R3 junk not stored
      end
      wr_idle(3, 8'h33);
      for (int i = 0; i < 4; i++) rd_byte();

      // R6: bus released
      rd_set(1'b0, 1'b1);
      @(posedge rd_clk); #1;
      check("R6 released bus", rd_data, '0);
      rd_set(1'b0, 1'b1);
      @(posedge rd_clk); #1;
      check("R6 released bus", rd_data, '0);
      // R6: driven but not fetching holds the last byte
      rd_set(1'b1, 1'b0);
      @(posedge rd_clk); #1;
      check("R6 hold last", rd_data, 8'hA3);
      rd_byte();
      rd_byte();                           // R6 pointer did not move: A4, A5
      rd_set(1'b1, 1'b0);

      // R8/R2: clear with strobe low, then a new frame from zero
      wr_clear(1'b0);
      for (int i = 0; i < 3; i++) wr_byte(8'hB0 + DATA_W'(i));
      wr_idle(3, 8'h77);
      rd_clear(1'b0);
      @(posedge rd_clk); #1;
      check("R8 clear over fetch", rd_data, '0);
      for (int i = 0; i < 6; i++) rd_byte();   // R2/R4: B0 B1 B2 A3 A4 A5
      rd_set(1'b1, 1'b0);
      @(posedge rd_clk); #1;
      check("R2 overwrite tail", rd_data, 8'hA5);

      // R7: wrap on both sides
      wr_clear(1'b1);
      for (int i = 0; i < DEPTH + 2; i++) wr_byte(DATA_W'(i * 7 + 3));
      wr_idle(3, 8'h11);
      rd_clear(1'b1);
      for (int i = 0; i < DEPTH + 2; i++) rd_byte();
      rd_set(1'b1, 1'b0);
      @(posedge rd_clk); #1;
      check("R7 wrapped read", rd_data, DATA_W'(17 * 7 + 3));

      // R9: concurrent writes (locations 2..7) and reads (8..13)
      for (int i = 0; i < 6; i++) rd_byte();
      fork
         begin
            for (int i = 0; i < 6; i++) wr_byte(8'hD0 + DATA_W'(i));
            wr_idle(3, 8'h22);
         end
         begin
            for (int i = 0; i < 6; i++) rd_byte();
            rd_set(1'b1, 1'b0);
         end
      join
      // R9: now read back the concurrently written region
      rd_clear(1'b1);
      rd_set(1'b1, 1'b0);
      rd_set(1'b1, 1'b0);
      rd_byte(); rd_byte();                    // locations 0,1
      for (int i = 0; i < 6; i++) rd_byte();   // D0..D5
      rd_set(1'b1, 1'b0);
      repeat (4) @(posedge rd_clk);
      #1;
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R5 scoreboard drain: got %0d expected 0", exp_q.size());
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule